// File: doc/BRIEF.md
# TLB Entry Maintenance Port

This block holds the 64-entry translation table and gives software a command port to maintain it. Each command is one strobed request: an operation code, a wide index operand, a 32-bit data word and the current process ID. Software can write or read the low word of an entry (page number, size code, valid flag, owning process ID) or the high word (physical page number and execute/write permissions). It can also look up which entry maps a given address, or drop every entry at once.

Page sizes are powers of four from 1 KB up to 16 MB and are chosen by a 3-bit code. The stored page number is always aligned to the page size. The owning process ID does not travel inside the data word. A low-word write copies it from the `cur_pid` input. A low-word read hands it back on a separate output, with a load strobe.

Every command completes in one clock. Read data and lookup results appear, registered, on the cycle after the request.

Top module: `tlb_maint_port`

## Requirements
- R1: Only bits [5:0] of `req_index` select the entry; bits [31:6] have no effect on any command.
- R2: A low-word write (op 1) takes size code n from `req_data[9:7]` (page size 1024 << 2n bytes). It stores the page number as `req_data & 32'hFFFFFC00`, with the bits below the page size also cleared.
- R3: A low-word write sets the entry's valid flag to `req_data[10]`.
- R4: A low-word write records `cur_pid` as the entry's owner. A low-word read (op 3) pulses `pid_load` with `pid_value` equal to that owner, in the same cycle as the read data.
- R5: A high-word write (op 2) stores `req_data & 32'hFFFFFC00` as the physical page number, `req_data[9]` as execute permission and `req_data[8]` as write permission. A high-word read (op 4) returns the physical page number OR 0x200 if execute is permitted OR 0x100 if write is permitted.
- R6: A high-word write leaves the entry's valid flag unchanged.
- R7: A low-word read returns the page number OR 0x400 if valid OR (size code << 7).
- R8: Invalidate-all (op 6) clears the valid flag of every entry and keeps all other fields.
- R9: A search (op 5, address in `req_data`) reports the lowest-numbered valid entry whose owner is 0 or equals `cur_pid` and whose page number equals the address masked to that entry's page size.
- R10: A search with no matching entry reports `srch_hit` = 0 and `srch_index` = 0.
- R11: `rsp_valid` is high exactly on the cycle after a read or search request and low otherwise. Writes, invalidate and op 0/7 produce no response.
- R12: Synchronous active-low reset clears every entry: reads then return 0 and searches miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one command per cycle |
| req_op | input | 3 | Command: 1 wr-lo, 2 wr-hi, 3 rd-lo, 4 rd-hi, 5 search, 6 invalidate-all |
| req_index | input | 32 | Entry index operand; low 6 bits used |
| req_data | input | 32 | Write word or search address |
| cur_pid | input | 8 | Current process ID |
| rsp_valid | output | 1 | Read or search result valid |
| rsp_rdata | output | 32 | Read word |
| srch_hit | output | 1 | Search found an entry |
| srch_index | output | 6 | Index of the found entry |
| pid_load | output | 1 | Load the process ID register from `pid_value` |
| pid_value | output | 8 | Owner ID of the entry read by a low-word read |

## Verification
A corrupted entry field shows up one cycle after the next read of that entry. A bad valid flag or owner ID also shows up in the next search that covers that address. The bench therefore pairs each write with a readback and with searches across overlapping pages. Those searches mix page sizes and wildcard owners, so a wrong mask, a wrong priority order or a stale valid flag changes the reported index at once. After an invalidate-all the bench reads entries back, which exposes a sweep that missed entries or that cleared fields it should have kept.

// File: rtl/tlb_maint_pkg.sv
// Package: shared widths, command codes and the entry record.
// Assumes a 32-bit address space and 8-bit process IDs.
package tlb_maint_pkg;

    localparam int ADDR_W    = 32;
    localparam int PID_W     = 8;
    localparam int SIZE_W    = 3;
    localparam int PAGE_LSB  = 10;   // smallest page is 1 KB

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_WR_LO = 3'd1,
        OP_WR_HI = 3'd2,
        OP_RD_LO = 3'd3,
        OP_RD_HI = 3'd4,
        OP_SRCH  = 3'd5,
        OP_INVAL = 3'd6,
        OP_RSVD  = 3'd7
    } tlb_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] epn;    // aligned virtual page number
        logic [ADDR_W-1:0] rpn;    // physical page number
        logic [SIZE_W-1:0] size;   // power-of-four size code
        logic [PID_W-1:0]  pid;    // owner, 0 = any
        logic              x_ok;   // execute permitted
        logic              w_ok;   // write permitted
    } tlb_entry_t;

    // Address mask that keeps the page-number bits for a size code.
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
        return {ADDR_W{1'b1}} << (PAGE_LSB + 2 * int'(code));
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
// Entry store: holds every table entry and its valid flag, and applies
// low/high writes and invalidate-all. It assumes at most one command per cycle.
module tlb_entry_store
    import tlb_maint_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_lo,
    input  logic                   wr_hi,
    input  logic                   inv_all,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [ADDR_W-1:0]      wr_data,
    input  logic [PID_W-1:0]       cur_pid,
    output tlb_entry_t             entries [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] valid_vec
);

    localparam logic [ADDR_W-1:0] LOW_CLR = {{(ADDR_W-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

    logic [SIZE_W-1:0] new_size;
    logic [ADDR_W-1:0] new_epn;
    logic [ADDR_W-1:0] new_rpn;
    logic              unused_bits;

    // Decode the write word into entry fields.
    always_comb begin
        new_size = wr_data[9:7];
        new_epn  = wr_data & LOW_CLR & page_mask(new_size);
        new_rpn  = wr_data & LOW_CLR;
    end

    assign unused_bits = ^wr_data[6:0];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = (wr_idx == IDX_W'(g));

        // One entry: reset, write, and invalidate-all.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g]   <= '0;
                valid_vec[g] <= 1'b0;
            end else if (inv_all) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_lo && sel) begin
                entries[g].epn  <= new_epn;
                entries[g].size <= new_size;
                entries[g].pid  <= cur_pid;
                valid_vec[g]    <= wr_data[10];
            end else if (wr_hi && sel) begin
                entries[g].rpn  <= new_rpn;
                entries[g].x_ok <= wr_data[9];
                entries[g].w_ok <= wr_data[8];
            end
        end
    end

    // R8: after invalidate-all no entry is valid.
    p_inval_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R6: a high-word write never changes a valid flag.
    p_hi_keeps_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !inv_all) |=> $stable(valid_vec));

    // R3: a low-word write with bit 10 set leaves that entry valid.
    p_lo_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !inv_all && wr_data[10]) |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/tlb_search.sv
// Search: combinational match of an address and process ID against every
// entry, with priority to the lowest index. It assumes that entry page
// numbers are already aligned to their page size.
module tlb_search
    import tlb_maint_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  tlb_entry_t             entries [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [PID_W-1:0]       pid,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx
);

    logic [NUM_ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic pid_ok;
        logic page_ok;
        // Per-entry owner and page comparison.
        always_comb begin
            pid_ok       = (entries[g].pid == '0) || (entries[g].pid == pid);
            page_ok      = ((addr & page_mask(entries[g].size)) == entries[g].epn);
            match_vec[g] = valid_vec[g] && pid_ok && page_ok;
        end
    end

    // Priority pick: the lowest matching index wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R9: a reported hit always names a valid entry.
    always_comb begin
        if (hit === 1'b1) begin
            p_hit_is_valid_r9: assert (valid_vec[hit_idx]);
        end
    end

endmodule

// File: rtl/tlb_word_fmt.sv
// Word formatter: packs one entry into its low and high readback words.
// It assumes that the page numbers have their low 10 bits clear.
module tlb_word_fmt
    import tlb_maint_pkg::*;
(
    input  tlb_entry_t        entry,
    input  logic              valid,
    output logic [ADDR_W-1:0] lo_word,
    output logic [ADDR_W-1:0] hi_word
);

    // Merge flags and the size code into the free low bits.
    always_comb begin
        lo_word       = entry.epn;
        lo_word[10]   = valid;
        lo_word[9:7]  = entry.size;
        hi_word       = entry.rpn;
        hi_word[9]    = entry.x_ok;
        hi_word[8]    = entry.w_ok;
    end

endmodule

// File: rtl/tlb_maint_port.sv
// Top: decodes software commands, drives the entry store, and registers
// read, search and process-ID results for the cycle after the request.
// It assumes one request per cycle, with the command on req_op.
module tlb_maint_port
    import tlb_maint_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [31:0]       req_index,
    input  logic [31:0]       req_data,
    input  logic [7:0]        cur_pid,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              srch_hit,
    output logic [IDX_W-1:0]  srch_index,
    output logic              pid_load,
    output logic [7:0]        pid_value
);

    tlb_op_e                op;
    logic                   do_wr_lo, do_wr_hi, do_rd_lo, do_rd_hi, do_srch, do_inv;
    logic [IDX_W-1:0]       idx;
    logic                   unused_index;
    tlb_entry_t             entries [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [ADDR_W-1:0]      lo_word, hi_word;
    logic                   s_hit;
    logic [IDX_W-1:0]       s_idx;

    // Command decode.
    always_comb begin
        op       = tlb_op_e'(req_op);
        do_wr_lo = req_valid && (op == OP_WR_LO);
        do_wr_hi = req_valid && (op == OP_WR_HI);
        do_rd_lo = req_valid && (op == OP_RD_LO);
        do_rd_hi = req_valid && (op == OP_RD_HI);
        do_srch  = req_valid && (op == OP_SRCH);
        do_inv   = req_valid && (op == OP_INVAL);
    end

    assign idx          = req_index[IDX_W-1:0];
    assign unused_index = ^req_index[31:IDX_W];

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (do_wr_lo),
        .wr_hi     (do_wr_hi),
        .inv_all   (do_inv),
        .wr_idx    (idx),
        .wr_data   (req_data),
        .cur_pid   (cur_pid),
        .entries   (entries),
        .valid_vec (valid_vec)
    );

    tlb_search #(.NUM_ENTRIES(NUM_ENTRIES)) u_search (
        .entries   (entries),
        .valid_vec (valid_vec),
        .addr      (req_data),
        .pid       (cur_pid),
        .hit       (s_hit),
        .hit_idx   (s_idx)
    );

    tlb_word_fmt u_fmt (
        .entry   (entries[idx]),
        .valid   (valid_vec[idx]),
        .lo_word (lo_word),
        .hi_word (hi_word)
    );

    // Response registers: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            srch_hit   <= 1'b0;
            srch_index <= '0;
            pid_load   <= 1'b0;
            pid_value  <= '0;
        end else begin
            rsp_valid <= do_rd_lo || do_rd_hi || do_srch;
            pid_load  <= do_rd_lo;
            if (do_rd_lo) begin
                rsp_rdata <= lo_word;
                pid_value <= entries[idx].pid;
            end
            if (do_rd_hi) begin
                rsp_rdata <= hi_word;
            end
            if (do_srch) begin
                srch_hit   <= s_hit;
                srch_index <= s_idx;
            end
        end
    end

    // R11: an idle cycle is never followed by a response.
    p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: a process-ID load only follows a low-word read.
    p_pid_load_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pid_load |-> (rsp_valid && $past(req_valid && req_op == 3'd3)));

    // R10: a search of an empty table misses.
    p_empty_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5 && valid_vec == '0) |=> (!srch_hit && srch_index == '0));

endmodule

// File: tb/tlb_maint_port_bench.sv
// Scoreboard bench: the driver mirrors the requirements in a table model and
// queues the expected responses; the monitor compares them on falling edges.
module tlb_maint_port_bench;

    typedef struct {
        string       tag;
        logic        is_srch;
        logic [31:0] rdata;
        logic        hit;
        logic [5:0]  sidx;
        logic        pload;
        logic [7:0]  pval;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_index = '0;
    logic [31:0] req_data = '0;
    logic [7:0]  cur_pid = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        srch_hit;
    logic [5:0]  srch_index;
    logic        pid_load;
    logic [7:0]  pid_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b1;
    exp_t q[$];

    // Table model.
    logic        m_v   [64];
    logic [31:0] m_epn [64];
    logic [2:0]  m_sz  [64];
    logic [31:0] m_rpn [64];
    logic        m_x   [64];
    logic        m_w   [64];
    logic [7:0]  m_pid [64];

    always #2 clk = ~clk;

    tlb_maint_port u_tlb_maint_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_data(req_data), .cur_pid(cur_pid),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .srch_hit(srch_hit),
        .srch_index(srch_index), .pid_load(pid_load), .pid_value(pid_value)
    );

    function automatic logic [31:0] mask_of(input logic [2:0] n);
        return 32'hFFFF_FFFF << (10 + 2 * int'(n));
    endfunction

    // Issue one command, update the model, and queue any response.
    task automatic issue(input logic [2:0] op, input logic [31:0] opnd,
                         input logic [31:0] data, input logic [7:0] pid,
                         input string tag);
        int   k;
        exp_t e;
        k = int'(opnd[5:0]);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_index = opnd;
        req_data = data; cur_pid = pid;
        e.tag = tag; e.is_srch = 1'b0; e.rdata = '0; e.hit = 1'b0;
        e.sidx = '0; e.pload = 1'b0; e.pval = '0;
        @(posedge clk);
        case (op)
            3'd1: begin
                m_sz[k]  = data[9:7];
                m_epn[k] = data & 32'hFFFF_FC00 & mask_of(data[9:7]);
                m_v[k]   = data[10];
                m_pid[k] = pid;
            end
            3'd2: begin
                m_rpn[k] = data & 32'hFFFF_FC00;
                m_x[k]   = data[9];
                m_w[k]   = data[8];
            end
            3'd3: begin
                e.rdata = m_epn[k] | (m_v[k] ? 32'h400 : 32'h0) | {22'd0, m_sz[k], 7'd0};
                e.pload = 1'b1; e.pval = m_pid[k];
                q.push_back(e);
            end
            3'd4: begin
                e.rdata = m_rpn[k] | (m_x[k] ? 32'h200 : 32'h0) | (m_w[k] ? 32'h100 : 32'h0);
                q.push_back(e);
            end
            3'd5: begin
                e.is_srch = 1'b1;
                for (int i = 63; i >= 0; i--) begin
                    if (m_v[i] && (m_pid[i] == 8'd0 || m_pid[i] == pid) &&
                        ((data & mask_of(m_sz[i])) == m_epn[i])) begin
                        e.hit = 1'b1; e.sidx = 6'(i);
                    end
                end
                q.push_back(e);
            end
            3'd6: for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    // Monitor: compare each response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (rsp_valid) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected response: rsp_valid 1 expected 0");
                end else begin
                    e = q.pop_front();
                    if (e.is_srch) begin
                        if (srch_hit !== e.hit || srch_index !== e.sidx) begin
                            errors++;
                            $display("FAIL %s search: hit %0b idx %0d expected hit %0b idx %0d",
                                     e.tag, srch_hit, srch_index, e.hit, e.sidx);
                        end
                        if (pid_load !== 1'b0) begin
                            errors++;
                            $display("FAIL R4 pid_load on search: %0b expected 0", pid_load);
                        end
                    end else begin
                        if (rsp_rdata !== e.rdata) begin
                            errors++;
                            $display("FAIL %s read data %h expected %h", e.tag, rsp_rdata, e.rdata);
                        end
                        if (pid_load !== e.pload || (e.pload && pid_value !== e.pval)) begin
                            errors++;
                            $display("FAIL R4 pid_load %0b value %h expected %0b value %h",
                                     pid_load, pid_value, e.pload, e.pval);
                        end
                    end
                end
            end else if (q.size() != 0) begin
                exp_t e;
                checks++;
                errors++;
                e = q.pop_front();
                $display("FAIL R11 (%s) response missing: rsp_valid 0 expected 1", e.tag);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && running) begin
            running = 1'b0;
            errors++;
            $display("FAIL watchdog: cycles %0d expected below 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_v[i] = 0; m_epn[i] = '0; m_sz[i] = '0; m_rpn[i] = '0;
            m_x[i] = 0; m_w[i] = 0; m_pid[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state.
        issue(3'd3, 32'd5, 32'd0, 8'd0, "R12");
        issue(3'd4, 32'd5, 32'd0, 8'd0, "R12");
        issue(3'd5, 32'd0, 32'h0000_0000, 8'd0, "R12");
        // R1 R2 R3 R7: low write through a wide operand, read back plain.
        issue(3'd1, 32'h0000_0143, 32'h1234_5678 | 32'h400 | (32'd1 << 7), 8'h12, "R2");
        issue(3'd3, 32'd3, 32'd0, 8'h00, "R7");
        issue(3'd3, 32'hFFFF_FFC3, 32'd0, 8'h00, "R1");
        // R2: 16 MB page alignment.
        issue(3'd1, 32'd10, 32'hABCD_EFFF & ~32'h0000_0380 | (32'd7 << 7), 8'h00, "R2");
        issue(3'd3, 32'd10, 32'd0, 8'h00, "R2");
        // R5 R6: high write and read.
        issue(3'd2, 32'd3, 32'h8765_4321, 8'h00, "R5");
        issue(3'd4, 32'd3, 32'd0, 8'h00, "R5");
        issue(3'd3, 32'd3, 32'd0, 8'h00, "R6");
        issue(3'd2, 32'd20, 32'hFFFF_FFFF, 8'h00, "R6");
        issue(3'd3, 32'd20, 32'd0, 8'h00, "R6");
        issue(3'd2, 32'd10, 32'h0000_0200, 8'h00, "R5");
        issue(3'd4, 32'd10, 32'd0, 8'h00, "R5");
        // R3: low write with bit 10 clear leaves the entry invalid.
        issue(3'd1, 32'd30, 32'h0000_5000, 8'h44, "R3");
        issue(3'd3, 32'd30, 32'd0, 8'h00, "R3");
        // R9: searches over owners, sizes and priority.
        issue(3'd1, 32'd2, 32'h1234_5000 | 32'h400 | (32'd1 << 7), 8'h33, "R9");
        issue(3'd5, 32'd0, 32'h1234_5ABC, 8'h12, "R9");
        issue(3'd5, 32'd0, 32'h1234_5ABC, 8'h33, "R9");
        issue(3'd5, 32'd0, 32'hABFF_0000, 8'h77, "R9");
        issue(3'd1, 32'd1, 32'h1234_5800 | 32'h400, 8'h00, "R9");
        issue(3'd5, 32'd0, 32'h1234_5ABC, 8'h12, "R9");
        issue(3'd5, 32'd0, 32'h1234_5400, 8'h12, "R9");
        issue(3'd5, 32'd0, 32'h0000_5123, 8'h44, "R9");
        // R10: misses.
        issue(3'd5, 32'd0, 32'h5555_5555, 8'h12, "R10");
        issue(3'd5, 32'd0, 32'h1234_5ABC, 8'h99, "R10");
        // R11: ignored op codes produce nothing.
        issue(3'd0, 32'd3, 32'd0, 8'h00, "R11");
        issue(3'd7, 32'd3, 32'd0, 8'h00, "R11");
        issue(3'd3, 32'd3, 32'd0, 8'h00, "R11");
        // R8: invalidate-all.
        issue(3'd6, 32'd0, 32'd0, 8'h00, "R8");
        issue(3'd5, 32'd0, 32'hABFF_0000, 8'h00, "R8");
        issue(3'd3, 32'd3, 32'd0, 8'h00, "R8");
        issue(3'd4, 32'd3, 32'd0, 8'h00, "R8");
        issue(3'd3, 32'd10, 32'd0, 8'h00, "R8");
        // R1: top index through an all-ones operand.
        issue(3'd1, 32'hFFFF_FFFF, 32'hFEDC_B400 | (32'd3 << 7), 8'hA5, "R1");
        issue(3'd3, 32'd63, 32'd0, 8'h00, "R1");
        issue(3'd5, 32'd0, 32'hFEDC_0000, 8'hA5, "R1");
        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11 pending responses %0d expected 0", q.size());
        end
        running = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule